// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This unit watches the already-synchronized levels of up to 128 general-purpose pins, arranged as four banks of 32. Each pin has a direction bit (1 means the pin drives an output) and separate enables for rising and falling edges. When an input pin makes an enabled transition, the unit sets that pin's bit in a sticky per-bank status register. The bit stays set until software clears it. Software clears bits by naming a bank and supplying a mask: each 1 in the mask clears the matching bit.

Three registered interrupt lines come from the status. Pin 0 and pin 1 each have their own line. All other pins share one combined line. A separate one-cycle wake pulse fires when the processor is halted and a wake-capable input pin changes level. The set of wake-capable pins is a fixed bitmap for each bank. Pins whose index is at or above the configured line count are treated as absent.

Top module: `gpio_edge_irq`

## Requirements
- R1: A status bit becomes 1 on the clock edge that first samples a pin going from 0 to 1, provided that pin's rising enable is 1 and its direction bit is 0.
- R2: A status bit becomes 1 on the clock edge that first samples a pin going from 1 to 0, provided that pin's falling enable is 1 and its direction bit is 0.
- R3: Status bits are sticky. A clear request with bank index b and mask m clears bit j of bank b wherever m[j] is 1. Mask bits that are 0, and all other banks, are unchanged.
- R4: If a qualifying edge and a clear of the same bit land in the same cycle, the bit stays 1.
- R5: `irq_pin0` equals status bit 0 of bank 0, and `irq_pin1` equals status bit 1 of bank 0. Both are registered and change on the same clock edge as the status.
- R6: `irq_shared` is the OR of bank 0 status bits 31..2 and every status bit of banks 1 to 3. It changes on the same clock edge as the status.
- R7: An edge never sets a status bit when the pin's direction bit is 1, or when the enable for that edge's polarity is 0.
- R8: While `halted` is 1, any level change on an input pin whose bit is set in the wake bitmap produces a one-cycle `wake_req` pulse on the edge that samples the change. Pin 32*b+j maps to bit j of the bitmap for bank b. The bitmaps for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R9: Pins with an index at or above NUM_LINES never set status and never cause a wake pulse.
- R10: After reset, all status bits, interrupt lines and the wake pulse are 0. The first clock after reset takes the current levels as the reference and detects no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | 128 | Synchronized pin levels; bit 32*b+j is pin j of bank b |
| pin_dir | input | 128 | Direction per pin, 1 = output |
| rise_en | input | 128 | Rising-edge enable per pin |
| fall_en | input | 128 | Falling-edge enable per pin |
| halted | input | 1 | Processor is halted |
| clr_valid | input | 1 | Clear request strobe |
| clr_bank | input | 2 | Bank targeted by the clear |
| clr_mask | input | 32 | Write-1-to-clear mask |
| status | output | 128 | Sticky edge status, same bit layout as pin_level |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Combined interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The status register and all four outputs are registered. A wrong previous-level register or a wrong status bit therefore appears at the ports on the clock edge that samples the next pin change. It shows as a missing, extra or wrongly placed status bit, or as a wrong interrupt or wake level, on that same edge. A lost clear, or a clear that hits the wrong bank, shows on the edge after the request. The bench drives one pin at a time across all 128 pins under a mix of enables and directions, and compares every output with an arithmetic model after each single-cycle step.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Registered outputs of the interrupt merge stage.
    typedef struct packed {
        logic pin0;
        logic pin1;
        logic shared;
        logic wake;
    } irq_out_t;

    // Fixed map of the pins allowed to wake a halted processor, per bank.
    function automatic logic [31:0] wake_bits(input int bank);
        case (bank)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int          W         = 32,
    parameter int          BANK_IDX  = 0,
    parameter int          NUM_LINES = 128,
    parameter logic [W-1:0] WAKE_MAP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         halted,
    input  logic         clr_hit,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status_d_o,
    output logic [W-1:0] status_q_o,
    output logic         wake_hit
);
    localparam int BASE = BANK_IDX * W;

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] status;
        logic         primed;
    } bank_state_t;

    bank_state_t  st_d, st_q;
    logic [W-1:0] line_ok;
    logic [W-1:0] watch;
    logic [W-1:0] clr_eff;
    logic [W-1:0] rise_hit;
    logic [W-1:0] fall_hit;

    for (genvar j = 0; j < W; j++) begin : g_line
        assign line_ok[j] = ((BASE + j) < NUM_LINES);
    end

    always_comb begin
        clr_eff     = clr_hit ? clr_mask : '0;
        watch       = ~dir & line_ok & {W{st_q.primed}};
        rise_hit    = level & ~st_q.prev & rise_en & watch;
        fall_hit    = ~level & st_q.prev & fall_en & watch;
        st_d.prev   = level;
        st_d.primed = 1'b1;
        // a fresh edge outranks a clear of the same bit
        st_d.status = (st_q.status & ~clr_eff) | rise_hit | fall_hit;
        wake_hit    = halted & (|((level ^ st_q.prev) & watch & WAKE_MAP));
        status_d_o  = st_d.status;
        status_q_o  = st_q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.status & $past(st_q.status) & ~$past(clr_eff)) == '0));

    // R7
    output_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status) & $past(dir)) == '0));

    // R1
    set_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status) & ~($past(level) ^ $past(st_q.prev))) == '0));

    // R9
    absent_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status) & ~line_ok) == '0));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] status_d,
    input  logic [NUM_BANKS-1:0]        wake_hit,
    output logic                        irq_pin0,
    output logic                        irq_pin1,
    output logic                        irq_shared,
    output logic                        wake_req
);
    localparam int TOTAL = NUM_BANKS * BANK_W;

    irq_out_t out_d, out_q;

    always_comb begin
        out_d.pin0   = status_d[0];
        out_d.pin1   = status_d[1];
        out_d.shared = |status_d[TOTAL-1:2];
        out_d.wake   = |wake_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_pin0   = out_q.pin0;
    assign irq_pin1   = out_q.pin1;
    assign irq_shared = out_q.shared;
    assign wake_req   = out_q.wake;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    parameter int NUM_LINES = 128,
    localparam int TOTAL    = NUM_BANKS * BANK_W,
    localparam int BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:0]  pin_level,
    input  logic [TOTAL-1:0]  pin_dir,
    input  logic [TOTAL-1:0]  rise_en,
    input  logic [TOTAL-1:0]  fall_en,
    input  logic              halted,
    input  logic              clr_valid,
    input  logic [BANK_IW-1:0] clr_bank,
    input  logic [BANK_W-1:0] clr_mask,
    output logic [TOTAL-1:0]  status,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared,
    output logic              wake_req
);
    logic [TOTAL-1:0]     status_d;
    logic [NUM_BANKS-1:0] wake_hit;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_hit;
        assign clr_hit = clr_valid && (clr_bank == BANK_IW'(b));

        gpio_edge_bank #(
            .W         (BANK_W),
            .BANK_IDX  (b),
            .NUM_LINES (NUM_LINES),
            .WAKE_MAP  (BANK_W'(wake_bits(b)))
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .level      (pin_level[b*BANK_W +: BANK_W]),
            .dir        (pin_dir[b*BANK_W +: BANK_W]),
            .rise_en    (rise_en[b*BANK_W +: BANK_W]),
            .fall_en    (fall_en[b*BANK_W +: BANK_W]),
            .halted     (halted),
            .clr_hit    (clr_hit),
            .clr_mask   (clr_mask),
            .status_d_o (status_d[b*BANK_W +: BANK_W]),
            .status_q_o (status[b*BANK_W +: BANK_W]),
            .wake_hit   (wake_hit[b])
        );
    end

    gpio_irq_merge #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_d   (status_d),
        .wake_hit   (wake_hit),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared),
        .wake_req   (wake_req)
    );

    // R5
    pin_lines_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin0 == status[0]) && (irq_pin1 == status[1]));

    // R6
    shared_line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared == (|status[TOTAL-1:2]));

    // R8
    wake_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(halted));

endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
    localparam int TOT   = 128;
    localparam int LINES = 120;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TOT-1:0] pin_level = '0;
    logic [TOT-1:0] pin_dir = '0;
    logic [TOT-1:0] rise_en = '0;
    logic [TOT-1:0] fall_en = '0;
    logic           halted = 1'b0;
    logic           clr_valid = 1'b0;
    logic [1:0]     clr_bank = '0;
    logic [31:0]    clr_mask = '0;
    logic [TOT-1:0] status;
    logic           irq_pin0, irq_pin1, irq_shared, wake_req;

    int checks = 0;
    int errors = 0;

    logic [TOT-1:0] lvl;
    logic [TOT-1:0] exp_st;
    logic [TOT-1:0] valid;
    logic [TOT-1:0] wake_map = {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};

    always #4 clk = ~clk;

    gpio_edge_irq #(.NUM_LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_dir(pin_dir),
        .rise_en(rise_en), .fall_en(fall_en), .halted(halted),
        .clr_valid(clr_valid), .clr_bank(clr_bank), .clr_mask(clr_mask),
        .status(status), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
        .irq_shared(irq_shared), .wake_req(wake_req)
    );

    task automatic check(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [TOT-1:0] nl, input logic hlt, input logic dc,
                        input logic [1:0] cb, input logic [31:0] cm,
                        input string ts, input string tw);
        logic [TOT-1:0] chg, edges, clr;
        logic ew;
        @(negedge clk);
        pin_level = nl; halted = hlt; clr_valid = dc; clr_bank = cb; clr_mask = cm;
        chg   = nl ^ lvl;
        edges = ((nl & chg & rise_en) | (~nl & chg & fall_en)) & ~pin_dir & valid;
        clr   = dc ? (TOT'(cm) << (32 * cb)) : '0;
        exp_st = (exp_st & ~clr) | edges;
        ew    = hlt & (|(chg & ~pin_dir & wake_map & valid));
        lvl   = nl;
        @(negedge clk);
        clr_valid = 1'b0;
        check(ts, status, exp_st);
        check("R5 pin0", TOT'(irq_pin0), TOT'(exp_st[0]));
        check("R5 pin1", TOT'(irq_pin1), TOT'(exp_st[1]));
        check("R6", TOT'(irq_shared), TOT'(|exp_st[TOT-1:2]));
        check(tw, TOT'(wake_req), TOT'(ew));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < TOT; i++) begin
            valid[i]   = (i < LINES);
            pin_dir[i] = (i % 7 == 3);
            rise_en[i] = (i % 3 != 2);
            fall_en[i] = (i % 4 != 1);
        end
        // R10: level already high during reset must not look like an edge
        pin_level = TOT'(32'h20);
        lvl = pin_level;
        exp_st = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 status", status, '0);
        check("R10 irq", TOT'({irq_pin0, irq_pin1, irq_shared, wake_req}), '0);

        // R1, R2, R8, R9: one pin at a time across every pin
        for (int i = 0; i < TOT; i++) begin
            step(lvl | (TOT'(1) << i), i[0], 1'b0, 2'd0, 32'd0,
                 (i >= LINES) ? "R9 rise" : "R1", (i >= LINES) ? "R9 wake" : "R8");
            step(lvl & ~(TOT'(1) << i), ~i[0], 1'b0, 2'd0, 32'd0,
                 (i >= LINES) ? "R9 fall" : "R2", (i >= LINES) ? "R9 wake" : "R8");
            if (i % 16 == 15) begin
                for (int b = 0; b < 4; b++)
                    step(lvl, 1'b0, 1'b1, 2'(b), 32'hFFFF_FFFF, "R3 clear", "R8");
            end
        end

        // R5 / R3: pin 0 sets, a zero mask and another bank leave it alone
        step(lvl | TOT'(1), 1'b0, 1'b0, 2'd0, 32'd0, "R5 set", "R8");
        step(lvl, 1'b0, 1'b1, 2'd0, 32'd0, "R3 zero mask", "R8");
        step(lvl, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R3 other bank", "R8");
        // R4: falling edge on pin 0 while the same bit is cleared
        step(lvl & ~TOT'(1), 1'b0, 1'b1, 2'd0, 32'h1, "R4", "R8");
        step(lvl, 1'b0, 1'b1, 2'd0, 32'h1, "R3 single bit", "R8");
        // R7: output pin 3 and rise-disabled pin 2 toggle
        step(lvl | TOT'(4'hC), 1'b1, 1'b0, 2'd0, 32'd0, "R7 rise", "R8");
        step(lvl & ~TOT'(4'hC), 1'b1, 1'b0, 2'd0, 32'd0, "R7 fall", "R8");
        // several pins at once, halted
        step({4{32'hA5C3_0F96}}, 1'b1, 1'b0, 2'd0, 32'd0, "R1 multi", "R8 multi");
        step({4{32'h5A3C_F069}}, 1'b1, 1'b0, 2'd2, 32'h0F0F_0F0F, "R2 multi", "R8 multi");
        step(lvl, 1'b1, 1'b0, 2'd0, 32'd0, "R3 hold", "R8 idle");
        for (int b = 0; b < 4; b++)
            step(lvl, 1'b0, 1'b1, 2'(b), 32'hFFFF_FFFF, "R3 final", "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule